// File: doc/BRIEF.md
# Floating-Point Special-Operand Override Unit

This block sits in front of a single-precision maths unit. It looks at the two operands and the operation code presented with a start strobe. It decides whether the answer is already fixed by the IEEE-754 rules for NaN, infinity, zero and negative arguments. If it is, the unit raises a one-cycle bypass pulse so that the controller can jump straight to completion. It also latches one of four override flags and a 3-bit select. That select steers the result multiplexer to the matching constant instead of the computed value.

The arithmetic itself lies outside this block. The computed result arrives on an input and is passed through whenever no override is latched. The unit classifies each operand from its sign bit and from all-zero and all-one detectors on its exponent and mantissa fields. A value of exactly 1.0 is also detected, for the logarithm rule. The override rules are chosen by the full 6-bit operation code.

The operation codes are: sin `000000`, cos `000001`, tan `000010`, sinh `000100`, cosh `000101`, tanh `000110`, exp `000111`, sqrt `100000`, multiply `101000`, divide `110000`, ln `111000`. Any other code never overrides.

Top module: `fp_special_override`

## Requirements
- R1: After reset, `bypass` is 0, all four flags are 0, `sel` is 0 and `result` equals `computed`.
- R2: An operand whose 8-bit exponent field (bits 30:23) is all zeros counts as zero, whatever its mantissa, so denormals are treated as zero.
- R3: A NaN operand (exponent all ones, mantissa nonzero) yields NaN for every listed operation. For multiply and divide this applies to either operand.
- R4: An infinite operand to sin, cos, tan, sinh, cosh or tanh yields NaN.
- R5: sqrt of a negative nonzero number yields NaN, and sqrt of plus infinity yields plus infinity.
- R6: ln of zero or of a negative number yields NaN, and ln of exactly 1.0 (0x3F800000) yields zero.
- R7: Multiply yields NaN for zero times infinity. Infinity times a nonzero number gives infinity, with the XOR of the operand signs as its sign. Zero times a finite number gives zero.
- R8: Divide yields NaN for 0/0 and for infinity/infinity. Any number over infinity gives zero. A nonzero number over zero gives infinity, signed by the XOR of the operand signs. Zero over a nonzero finite number gives zero.
- R9: The decision is registered on the clock edge where `start` is 1. `bypass` is 1 for exactly the following cycle when a special case was found. The flags and `sel` then hold until the next `start`.
- R10: The `sel` codes are 0 computed, 1 +inf, 2 -inf, 3 zero and 4 NaN. They put 0x7F800000, 0xFF800000, 0x00000000 and 0x7FC00000 on `result`. At most one flag is set, and exactly one is set while `bypass` is 1.
- R11: When no rule applies (this includes unlisted codes and finite ordinary operands), `sel` is 0 and `result` follows `computed` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operands and code are valid; latch a decision |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand (multiply, divide) |
| opcode | input | 6 | Operation code, group in bits 5:3 |
| computed | input | 32 | Result from the arithmetic datapath |
| bypass | output | 1 | One-cycle pulse: result is fixed, skip computation |
| flag_pinf | output | 1 | Override is plus infinity |
| flag_ninf | output | 1 | Override is minus infinity |
| flag_zero | output | 1 | Override is zero |
| flag_nan | output | 1 | Override is quiet NaN |
| sel | output | 3 | Result multiplexer select |
| result | output | 32 | Override constant or computed value |

## Verification
The assertions assume that `start`, the operands and the code hold known values at every rising edge after reset. They also assume that a decision is judged only in the cycle after `start`. The bench drives all inputs on the falling edge and pulses `start` for a single cycle. It then leaves `start` low for at least one full cycle, so that the pulse-and-hold property can be seen before the next decision. Operands are picked so that each rule is reached through one field pattern only. Denormals, signed infinities and exact 1.0 are placed deliberately at the rule boundaries.

// File: rtl/fpso_pkg.sv
// Shared widths, operation codes and override kinds for the special-operand
// override unit. Assumes single-precision layout: sign, exponent, mantissa.
package fpso_pkg;
    parameter int EXP_W = 8;
    parameter int MAN_W = 23;
    parameter int OP_W  = 6;
    localparam int FP_W = 1 + EXP_W + MAN_W;
    localparam int SEL_W = 3;
    localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};

    localparam logic [OP_W-1:0] OPC_SIN  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_COS  = 6'b000001;
    localparam logic [OP_W-1:0] OPC_TAN  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_SINH = 6'b000100;
    localparam logic [OP_W-1:0] OPC_COSH = 6'b000101;
    localparam logic [OP_W-1:0] OPC_TANH = 6'b000110;
    localparam logic [OP_W-1:0] OPC_EXP  = 6'b000111;
    localparam logic [OP_W-1:0] OPC_SQRT = 6'b100000;
    localparam logic [OP_W-1:0] OPC_MUL  = 6'b101000;
    localparam logic [OP_W-1:0] OPC_DIV  = 6'b110000;
    localparam logic [OP_W-1:0] OPC_LN   = 6'b111000;

    typedef enum logic [SEL_W-1:0] {
        OVR_NONE = 3'd0,
        OVR_PINF = 3'd1,
        OVR_NINF = 3'd2,
        OVR_ZERO = 3'd3,
        OVR_NAN  = 3'd4
    } ovr_e;

    typedef struct packed {
        logic sign;
        logic exp_zero;
        logic exp_ones;
        logic man_zero;
        logic is_one;
    } fld_t;

    localparam logic [FP_W-1:0] CONST_PINF = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [FP_W-1:0] CONST_NINF = {1'b1, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    localparam logic [FP_W-1:0] CONST_ZERO = '0;
    localparam logic [FP_W-1:0] CONST_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
endpackage

// File: rtl/fpso_field_detect.sv
// Field detector for one operand: sign, all-zero and all-one exponent,
// all-zero mantissa, plus an exact-1.0 match. Purely combinational.
module fpso_field_detect
    import fpso_pkg::*;
(
    input  logic [FP_W-1:0] val,
    output fld_t            fld
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    // split the word into its fields
    assign exp_f = val[FP_W-2 -: EXP_W];
    assign man_f = val[MAN_W-1:0];

    // build the detector outputs
    always_comb begin
        fld.sign     = val[FP_W-1];
        fld.exp_zero = ~|exp_f;
        fld.exp_ones = &exp_f;
        fld.man_zero = ~|man_f;
        fld.is_one   = ~val[FP_W-1] && (exp_f == EXP_BIAS) && ~|man_f;
    end
endmodule

// File: rtl/fpso_rule_engine.sv
// Per-operation override rules. Maps the two operand classifications and the
// opcode to an override kind. Denormals count as zero (exponent all zeros).
module fpso_rule_engine
    import fpso_pkg::*;
(
    input  fld_t            fa,
    input  fld_t            fb,
    input  logic [OP_W-1:0] opcode,
    output ovr_e            kind
);
    logic a_nan, a_inf, a_zero, a_neg;
    logic b_nan, b_inf, b_zero;
    ovr_e inf_kind;

    // derive operand classes from the detector outputs
    assign a_nan  = fa.exp_ones & ~fa.man_zero;
    assign a_inf  = fa.exp_ones &  fa.man_zero;
    assign a_zero = fa.exp_zero;
    assign a_neg  = fa.sign & ~a_zero & ~a_nan;
    assign b_nan  = fb.exp_ones & ~fb.man_zero;
    assign b_inf  = fb.exp_ones &  fb.man_zero;
    assign b_zero = fb.exp_zero;
    assign inf_kind = (fa.sign ^ fb.sign) ? OVR_NINF : OVR_PINF;

    // choose the override for the current operation
    always_comb begin
        kind = OVR_NONE;
        case (opcode)
            OPC_SIN, OPC_COS, OPC_TAN, OPC_SINH, OPC_COSH, OPC_TANH: begin
                if (a_nan || a_inf) kind = OVR_NAN;
            end
            OPC_EXP: begin
                if (a_nan) kind = OVR_NAN;
            end
            OPC_SQRT: begin
                if (a_nan || a_neg)  kind = OVR_NAN;
                else if (a_inf)      kind = OVR_PINF;
            end
            OPC_LN: begin
                if (a_nan || a_neg || a_zero) kind = OVR_NAN;
                else if (fa.is_one)           kind = OVR_ZERO;
            end
            OPC_MUL: begin
                if (a_nan || b_nan || (a_zero && b_inf) || (a_inf && b_zero))
                    kind = OVR_NAN;
                else if (a_inf || b_inf)   kind = inf_kind;
                else if (a_zero || b_zero) kind = OVR_ZERO;
            end
            OPC_DIV: begin
                if (a_nan || b_nan || (a_zero && b_zero) || (a_inf && b_inf))
                    kind = OVR_NAN;
                else if (b_inf)  kind = OVR_ZERO;
                else if (b_zero) kind = inf_kind;
                else if (a_zero) kind = OVR_ZERO;
            end
            default: kind = OVR_NONE;
        endcase
    end
endmodule

// File: rtl/fpso_result_mux.sv
// Result multiplexer: picks a special constant or the computed value
// according to the registered override kind.
module fpso_result_mux
    import fpso_pkg::*;
(
    input  ovr_e            sel_kind,
    input  logic [FP_W-1:0] computed,
    output logic [FP_W-1:0] result
);
    // steer the output word
    always_comb begin
        case (sel_kind)
            OVR_PINF: result = CONST_PINF;
            OVR_NINF: result = CONST_NINF;
            OVR_ZERO: result = CONST_ZERO;
            OVR_NAN:  result = CONST_QNAN;
            default:  result = computed;
        endcase
    end
endmodule

// File: rtl/fp_special_override.sv
// Top of the special-operand override unit. Classifies both operands,
// applies the rules for the opcode, and registers the decision on start.
// Assumes start is a single-cycle strobe with operands valid in that cycle.
module fp_special_override
    import fpso_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         op_a,
    input  logic [31:0]         op_b,
    input  logic [5:0]          opcode,
    input  logic [31:0]         computed,
    output logic                bypass,
    output logic                flag_pinf,
    output logic                flag_ninf,
    output logic                flag_zero,
    output logic                flag_nan,
    output logic [2:0]          sel,
    output logic [31:0]         result
);
    localparam int N_OPND = 2;

    logic [FP_W-1:0] opnd [N_OPND];
    fld_t            fld  [N_OPND];
    ovr_e            kind_d;
    ovr_e            kind_q;
    logic            bypass_q;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    // one field detector per operand
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_det
        fpso_field_detect u_det (
            .val (opnd[gi]),
            .fld (fld[gi])
        );
    end

    fpso_rule_engine u_rules (
        .fa     (fld[0]),
        .fb     (fld[1]),
        .opcode (opcode),
        .kind   (kind_d)
    );

    // latch the decision on start and pulse bypass for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= OVR_NONE;
            bypass_q <= 1'b0;
        end else begin
            bypass_q <= start && (kind_d != OVR_NONE);
            if (start) kind_q <= kind_d;
        end
    end

    fpso_result_mux u_mux (
        .sel_kind (kind_q),
        .computed (computed),
        .result   (result)
    );

    assign bypass    = bypass_q;
    assign sel       = kind_q;
    assign flag_pinf = (kind_q == OVR_PINF);
    assign flag_ninf = (kind_q == OVR_NINF);
    assign flag_zero = (kind_q == OVR_ZERO);
    assign flag_nan  = (kind_q == OVR_NAN);
endmodule

// File: rtl/fpso_checker.sv
// Property checker for the override unit, attached by bind.
module fpso_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [5:0]  opcode,
    input logic [31:0] computed,
    input logic        bypass,
    input logic        flag_pinf,
    input logic        flag_ninf,
    input logic        flag_zero,
    input logic        flag_nan,
    input logic [2:0]  sel,
    input logic [31:0] result
);
    logic [3:0] flags;
    assign flags = {flag_nan, flag_zero, flag_ninf, flag_pinf};

    p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    p_bypass_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> ($countones(flags) == 1));

    p_nan_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_nan |-> (result == 32'h7FC0_0000));

    p_bypass_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !bypass);

    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(sel));

    p_passthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 4'b0000) |-> (result == computed));

    p_mul_zero_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == 6'b101000 && op_a[30:23] == 8'h00
               && op_b[30:0] == 31'h7F80_0000) |=> flag_nan);

    p_sin_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == 6'b000000 && op_a[30:23] == 8'hFF
               && op_a[22:0] != 23'd0) |=> flag_nan);
endmodule

bind fp_special_override fpso_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_a      (op_a),
    .op_b      (op_b),
    .opcode    (opcode),
    .computed  (computed),
    .bypass    (bypass),
    .flag_pinf (flag_pinf),
    .flag_ninf (flag_ninf),
    .flag_zero (flag_zero),
    .flag_nan  (flag_nan),
    .sel       (sel),
    .result    (result)
);

// File: tb/sim_fp_special_override.sv
// Directed bench for the special-operand override unit.
module sim_fp_special_override;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [5:0]  opcode = '0;
    logic [31:0] computed = '0;
    logic        bypass;
    logic        flag_pinf, flag_ninf, flag_zero, flag_nan;
    logic [2:0]  sel;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [5:0] C_SIN = 6'b000000, C_COS = 6'b000001, C_TANH = 6'b000110,
                           C_EXP = 6'b000111, C_SQRT = 6'b100000, C_MUL = 6'b101000,
                           C_DIV = 6'b110000, C_LN = 6'b111000, C_OTHER = 6'b001000;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000,
                            QNAN = 32'h7FC0_0000, SNAN = 32'h7F80_0001,
                            ONE = 32'h3F80_0000, TWO = 32'h4000_0000;

    always #5 clk = ~clk;

    fp_special_override u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .computed(computed), .bypass(bypass),
        .flag_pinf(flag_pinf), .flag_ninf(flag_ninf), .flag_zero(flag_zero),
        .flag_nan(flag_nan), .sel(sel), .result(result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // kind: 0 none, 1 +inf, 2 -inf, 3 zero, 4 NaN
    function automatic logic [31:0] word_of(input int kind, input logic [31:0] cw);
        case (kind)
            1: return PINF;
            2: return NINF;
            3: return 32'h0;
            4: return QNAN;
            default: return cw;
        endcase
    endfunction

    // drive one operation, then check the decision cycle and the hold cycle
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [5:0] op, input int kind);
        logic [31:0] cw;
        logic [3:0]  fexp;
        cw = 32'h1234_0000 ^ a ^ {b[15:0], b[31:16]};
        fexp = (kind == 1) ? 4'b0001 : (kind == 2) ? 4'b0010 :
               (kind == 3) ? 4'b0100 : (kind == 4) ? 4'b1000 : 4'b0000;
        @(negedge clk);
        op_a = a; op_b = b; opcode = op; computed = cw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " bypass"}, {63'd0, bypass}, {63'd0, (kind != 0)});
        check({req, " flags"}, {60'd0, flag_nan, flag_zero, flag_ninf, flag_pinf}, {60'd0, fexp});
        check({req, " sel"}, {61'd0, sel}, 64'(kind));
        check({req, " result"}, {32'd0, result}, {32'd0, word_of(kind, cw)});
        // R9 hold: bypass drops, decision stays; change computed to expose the mux
        computed = ~cw;
        @(negedge clk);
        check("R9 bypass pulse", {63'd0, bypass}, 64'd0);
        check("R9 sel held", {61'd0, sel}, 64'(kind));
        check("R9 result held", {32'd0, result}, {32'd0, word_of(kind, ~cw)});
    endtask

    task automatic t_reset();
        computed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R1 bypass", {63'd0, bypass}, 64'd0);
        check("R1 flags", {60'd0, flag_nan, flag_zero, flag_ninf, flag_pinf}, 64'd0);
        check("R1 sel", {61'd0, sel}, 64'd0);
        check("R1 result", {32'd0, result}, {32'd0, 32'h1234_5678});
        rst_n = 1'b1;
    endtask

    task automatic t_nan_in();
        run_op("R3 sin NaN", SNAN, 32'h0, C_SIN, 4);
        run_op("R3 exp NaN", 32'hFFC0_0000, 32'h0, C_EXP, 4);
        run_op("R3 mul b NaN", TWO, SNAN, C_MUL, 4);
        run_op("R3 div a NaN", SNAN, TWO, C_DIV, 4);
        run_op("R3 sqrt NaN", SNAN, 32'h0, C_SQRT, 4);
    endtask

    task automatic t_trig_inf();
        run_op("R4 cos +inf", PINF, 32'h0, C_COS, 4);
        run_op("R4 tanh -inf", NINF, 32'h0, C_TANH, 4);
        run_op("R4 sin finite", TWO, 32'h0, C_SIN, 0);
    endtask

    task automatic t_sqrt();
        run_op("R5 sqrt neg", 32'hC000_0000, 32'h0, C_SQRT, 4);
        run_op("R5 sqrt +inf", PINF, 32'h0, C_SQRT, 1);
        run_op("R5 sqrt -inf", NINF, 32'h0, C_SQRT, 4);
        run_op("R5 sqrt 4", 32'h4080_0000, 32'h0, C_SQRT, 0);
    endtask

    task automatic t_ln();
        run_op("R6 ln 0", 32'h0, 32'h0, C_LN, 4);
        run_op("R6 ln -1", 32'hBF80_0000, 32'h0, C_LN, 4);
        run_op("R6 ln 1", ONE, 32'h0, C_LN, 3);
        run_op("R6 ln 2", TWO, 32'h0, C_LN, 0);
        run_op("R6 ln just above 1", 32'h3F80_0001, 32'h0, C_LN, 0);
    endtask

    task automatic t_mul();
        run_op("R7 mul 0*inf", 32'h0, PINF, C_MUL, 4);
        run_op("R7 mul -3*+inf", 32'hC040_0000, PINF, C_MUL, 2);
        run_op("R7 mul -inf*-2", NINF, 32'hC000_0000, C_MUL, 1);
        run_op("R7 mul 0*5", 32'h0, 32'h40A0_0000, C_MUL, 3);
        run_op("R7 mul 2*3", TWO, 32'h4040_0000, C_MUL, 0);
    endtask

    task automatic t_div();
        run_op("R8 div 0/0", 32'h0, 32'h8000_0000, C_DIV, 4);
        run_op("R8 div inf/inf", PINF, NINF, C_DIV, 4);
        run_op("R8 div 5/inf", 32'h40A0_0000, NINF, C_DIV, 3);
        run_op("R8 div -5/0", 32'hC0A0_0000, 32'h0, C_DIV, 2);
        run_op("R8 div 0/7", 32'h0, 32'h40E0_0000, C_DIV, 3);
        run_op("R8 div 6/3", 32'h40C0_0000, 32'h4040_0000, C_DIV, 0);
    endtask

    task automatic t_denorm();
        run_op("R2 mul denorm*inf", 32'h0000_0001, PINF, C_MUL, 4);
        run_op("R2 div 1/denorm", ONE, 32'h0000_0010, C_DIV, 1);
        run_op("R2 ln denorm", 32'h007F_FFFF, 32'h0, C_LN, 4);
    endtask

    task automatic t_passthru();
        run_op("R11 unlisted code NaN", SNAN, SNAN, C_OTHER, 0);
        run_op("R11 exp +inf", PINF, 32'h0, C_EXP, 0);
        // live follow with no override latched
        @(negedge clk);
        computed = 32'hDEAD_BEEF;
        #1;
        check("R11 live follow", {32'd0, result}, {32'd0, 32'hDEAD_BEEF});
        // R10: a special then a plain start clears the override
        run_op("R10 nan then", SNAN, 32'h0, C_SIN, 4);
        run_op("R10 cleared", TWO, TWO, C_MUL, 0);
    endtask

    initial begin
        t_reset();
        t_nan_in();
        t_trig_inf();
        t_sqrt();
        t_ln();
        t_mul();
        t_div();
        t_denorm();
        t_passthru();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule